// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Unit

This unit holds the controller-wide registers of a four-channel DMA controller: an 8-bit command register, a per-channel mask, a status byte and one mode byte per channel. The host reaches it through port indices 8 to 15. Each index is decoded into a control action such as a command write, request-register write, single-mask or whole-mask update, mask clear, mode write, flip-flop clear or master reset. Reads return either the status byte or the mask.

Outside the host path, per-channel hold and release inputs set and clear each channel's request bit. A per-channel terminal-count input sets each channel's done bit. From the mask and the request bits the unit forms a run-enable vector that tells the transfer engine which channels may be served. The address and count registers are not part of this unit. It drives a one-cycle flip-flop clear pulse for them. Port indices 0 to 7 belong to those registers, and an access to one of them raises a one-cycle error flag here.

Top module: `dmac_ctrl_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the unit is in this state: mask all ones, status 0x00, command 0x00, every mode byte 0x00, run_en 0.
- R2: A write to port 8 stores wr_data in the command register only if wr_data has no bit set other than bit 2, which means only 0x00 and 0x04 are accepted. Any other value leaves the command unchanged. The command is visible on ctrl_cmd from the cycle after the write.
- R3: A write to port 9 selects channel c = wr_data[1:0]. It sets status bit c+4 to wr_data[2] and always clears status bit c.
- R4: A write to port 10 sets the mask bit of channel wr_data[1:0] to wr_data[2].
- R5: A write to port 11 stores wr_data as the mode byte of channel wr_data[1:0]. Channel c's mode appears on chan_mode[8c+7:8c].
- R6: A write to port 12 or to port 13 drives ff_clear high for exactly the next cycle.
- R7: A write to port 13 sets the mask to all ones and clears status and command. Mode bytes are kept.
- R8: A write to port 14 clears every mask bit. A write to port 15 loads the mask from wr_data[3:0].
- R9: While rd_en is high, rd_data shows the following in the same cycle: status for port 8, the mask zero-extended for port 15, and 0x00 for every other port. A status read clears status bits 3:0 at the end of that cycle.
- R10: run_en[c] is 1 exactly when mask bit c is 0 and status bit c+4 is 1.
- R11: Within one cycle the updates apply in this order: the host action, then term_cnt sets status bits 3:0, then hold_req sets status bits 7:4, then release_req clears status bits 7:4.
- R12: A read or write to a port index below 8 raises port_err for the next cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_idx | input | 4 | Host port index |
| wr_data | input | 8 | Host write data |
| hold_req | input | NUM_CH | Per-channel request set |
| release_req | input | NUM_CH | Per-channel request clear |
| term_cnt | input | NUM_CH | Per-channel terminal-count set |
| rd_data | output | 8 | Host read data |
| ctrl_cmd | output | 8 | Command register |
| chan_mode | output | 8*NUM_CH | Mode bytes, channel 0 in the low byte |
| run_en | output | NUM_CH | Channels eligible for service |
| ff_clear | output | 1 | Byte flip-flop clear pulse |
| port_err | output | 1 | Unknown port index pulse |

## Verification
The bench builds the unit with the default NUM_CH of 4. This is the only value at which the status byte is completely filled, with four done bits below four request bits. At this value every channel-select code of the request, mask and mode writes addresses a real channel. The random phase can then hit every channel through every path, including requests held and released in the same cycle and terminal counts that coincide with status reads.

// File: rtl/dmac_ctrl_pkg.sv
// Package: port index codes, command acceptance mask and decoded action type
// shared by the control unit and its submodules.
package dmac_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int PORT_W = 4;

    localparam logic [PORT_W-1:0] PI_CMD   = 4'd8;
    localparam logic [PORT_W-1:0] PI_REQ   = 4'd9;
    localparam logic [PORT_W-1:0] PI_SMASK = 4'd10;
    localparam logic [PORT_W-1:0] PI_MODE  = 4'd11;
    localparam logic [PORT_W-1:0] PI_FFCLR = 4'd12;
    localparam logic [PORT_W-1:0] PI_MRST  = 4'd13;
    localparam logic [PORT_W-1:0] PI_MCLR  = 4'd14;
    localparam logic [PORT_W-1:0] PI_MALL  = 4'd15;

    // Only the controller-disable bit may be set in an accepted command
    localparam logic [BYTE_W-1:0] CMD_ALLOWED = 8'h04;
    // Bit of request / single-mask writes carrying the set/clear flag
    localparam int FLAG_BIT = 2;

    typedef struct packed {
        logic cmd_wr;
        logic req_wr;
        logic smask_wr;
        logic mode_wr;
        logic ffclr_wr;
        logic mrst_wr;
        logic mclr_wr;
        logic mall_wr;
        logic stat_rd;
        logic mask_rd;
        logic bad_port;
    } ctrl_op_t;
endpackage

// File: rtl/dmac_port_decode.sv
// Port decoder: turns a host read or write at a port index into one decoded
// action. Assumes wr_en and rd_en are not high together; indices below 8
// are owned elsewhere and flagged as bad.
module dmac_port_decode
    import dmac_ctrl_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] port_idx,
    output ctrl_op_t          op
);
    logic hi_range;

    // Purpose: decode strobe and index into a single action.
    always_comb begin
        hi_range    = port_idx[PORT_W-1];
        op          = '0;
        op.bad_port = (wr_en | rd_en) & ~hi_range;
        if (wr_en && hi_range) begin
            case (port_idx)
                PI_CMD:   op.cmd_wr   = 1'b1;
                PI_REQ:   op.req_wr   = 1'b1;
                PI_SMASK: op.smask_wr = 1'b1;
                PI_MODE:  op.mode_wr  = 1'b1;
                PI_FFCLR: op.ffclr_wr = 1'b1;
                PI_MRST:  op.mrst_wr  = 1'b1;
                PI_MCLR:  op.mclr_wr  = 1'b1;
                default:  op.mall_wr  = 1'b1;
            endcase
        end
        if (rd_en && hi_range) begin
            op.stat_rd = (port_idx == PI_CMD);
            op.mask_rd = (port_idx == PI_MALL);
        end
    end
endmodule

// File: rtl/dmac_mode_bank.sv
// Mode bank: one mode byte per channel, written when the channel field of
// the write data matches. Assumes NUM_CH is 2 to 4; master reset keeps modes.
module dmac_mode_bank
    import dmac_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_wr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NUM_CH*BYTE_W-1:0] chan_mode
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
        logic [BYTE_W-1:0] mode_q;

        // Purpose: hold channel c's mode byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q <= '0;
            else if (mode_wr && (wr_data[CH_W-1:0] == CH_W'(c)))
                mode_q <= wr_data;
        end

        assign chan_mode[c*BYTE_W +: BYTE_W] = mode_q;
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
// Control registers: command, mask and status plus the flip-flop clear and
// bad-port pulses. Status holds done bits in [NUM_CH-1:0] and request bits
// in [2*NUM_CH-1:NUM_CH]. Assumes NUM_CH is 2 to 4.
module dmac_ctrl_regs
    import dmac_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int STAT_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_op_t          op,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] hold_req,
    input  logic [NUM_CH-1:0] release_req,
    input  logic [NUM_CH-1:0] term_cnt,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              ff_clear_q,
    output logic              port_err_q
);
    logic [BYTE_W-1:0] cmd_n;
    logic [NUM_CH-1:0] mask_n;
    logic [STAT_W-1:0] stat_n;
    logic [CH_W-1:0]   sel;
    logic [NUM_CH-1:0] done_n, req_n;

    assign sel = wr_data[CH_W-1:0];

    // Purpose: next command, accepting only values inside the allowed set.
    always_comb begin
        cmd_n = cmd_q;
        if (op.cmd_wr && ((wr_data & ~CMD_ALLOWED) == '0))
            cmd_n = wr_data;
        if (op.mrst_wr)
            cmd_n = '0;
    end

    // Purpose: next mask from single, whole, clear and reset actions.
    always_comb begin
        mask_n = mask_q;
        if (op.smask_wr)
            mask_n[sel] = wr_data[FLAG_BIT];
        if (op.mclr_wr)
            mask_n = '0;
        if (op.mall_wr)
            mask_n = wr_data[NUM_CH-1:0];
        if (op.mrst_wr)
            mask_n = '1;
    end

    // Purpose: next status; host action first, then done, hold, release.
    always_comb begin
        done_n = stat_q[NUM_CH-1:0];
        req_n  = stat_q[STAT_W-1:NUM_CH];
        if (op.stat_rd)
            done_n = '0;
        if (op.req_wr) begin
            req_n[sel]  = wr_data[FLAG_BIT];
            done_n[sel] = 1'b0;
        end
        if (op.mrst_wr) begin
            done_n = '0;
            req_n  = '0;
        end
        done_n = done_n | term_cnt;
        req_n  = (req_n | hold_req) & ~release_req;
        stat_n = {req_n, done_n};
    end

    // Purpose: register state and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            mask_q     <= '1;
            stat_q     <= '0;
            ff_clear_q <= 1'b0;
            port_err_q <= 1'b0;
        end else begin
            cmd_q      <= cmd_n;
            mask_q     <= mask_n;
            stat_q     <= stat_n;
            ff_clear_q <= op.ffclr_wr | op.mrst_wr;
            port_err_q <= op.bad_port;
        end
    end
endmodule

// File: rtl/dmac_ctrl_unit.sv
// Top: DMA controller command/mask/status unit. Decodes host accesses to
// ports 8..15, keeps controller registers and per-channel modes, and forms
// the run-enable vector. Assumes NUM_CH of 2 to 4 and exclusive rd/wr strobes.
module dmac_ctrl_unit
    import dmac_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [PORT_W-1:0]        port_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]        hold_req,
    input  logic [NUM_CH-1:0]        release_req,
    input  logic [NUM_CH-1:0]        term_cnt,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [BYTE_W-1:0]        ctrl_cmd,
    output logic [NUM_CH*BYTE_W-1:0] chan_mode,
    output logic [NUM_CH-1:0]        run_en,
    output logic                     ff_clear,
    output logic                     port_err
);
    localparam int STAT_W = 2 * NUM_CH;

    ctrl_op_t          op;
    logic [NUM_CH-1:0] mask_q;
    logic [STAT_W-1:0] stat_q;

    dmac_port_decode u_dec (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_idx (port_idx),
        .op       (op)
    );

    dmac_ctrl_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wr_data     (wr_data),
        .hold_req    (hold_req),
        .release_req (release_req),
        .term_cnt    (term_cnt),
        .cmd_q       (ctrl_cmd),
        .mask_q      (mask_q),
        .stat_q      (stat_q),
        .ff_clear_q  (ff_clear),
        .port_err_q  (port_err)
    );

    dmac_mode_bank #(.NUM_CH(NUM_CH)) u_modes (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (op.mode_wr),
        .wr_data   (wr_data),
        .chan_mode (chan_mode)
    );

    // Purpose: read data multiplexer, zero for unmapped reads.
    always_comb begin
        rd_data = '0;
        if (op.stat_rd)
            rd_data = BYTE_W'(stat_q);
        else if (op.mask_rd)
            rd_data = BYTE_W'(mask_q);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_run
        assign run_en[c] = ~mask_q[c] & stat_q[NUM_CH + c];
    end
endmodule

// File: rtl/dmac_ctrl_unit_chk.sv
// Checker: temporal properties of the control unit at its ports.
module dmac_ctrl_unit_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [3:0]        port_idx,
    input logic [NUM_CH-1:0] release_req,
    input logic [7:0]        ctrl_cmd,
    input logic [NUM_CH-1:0] run_en,
    input logic              ff_clear,
    input logic              port_err
);
    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cmd & 8'hFB) == 8'h00); // R2

    AST_BAD_PORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !port_idx[3]) |=> port_err); // R12

    AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_en || rd_en) && !port_idx[3]) |=> !port_err); // R12

    AST_FF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_idx == 4'd12) |=> ff_clear); // R6

    AST_MASTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_idx == 4'd13) |=> (run_en == '0 && ctrl_cmd == 8'h00 && ff_clear)); // R7

    AST_RELEASE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req != '0) |=> ((run_en & $past(release_req)) == '0)); // R11
endmodule

bind dmac_ctrl_unit dmac_ctrl_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .port_idx    (port_idx),
    .release_req (release_req),
    .ctrl_cmd    (ctrl_cmd),
    .run_en      (run_en),
    .ff_clear    (ff_clear),
    .port_err    (port_err)
);

// File: tb/test_dmac_ctrl_unit.sv
module test_dmac_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  port_idx;
    logic [7:0]  wr_data;
    logic [3:0]  hold_req, release_req, term_cnt;
    logic [7:0]  rd_data, ctrl_cmd;
    logic [31:0] chan_mode;
    logic [3:0]  run_en;
    logic        ff_clear, port_err;

    int errors = 0;
    int checks = 0;
    logic [7:0] last_rd;

    // reference state
    logic [7:0] cmd_m, stat_m;
    logic [3:0] mask_m;
    logic [7:0] mode_m [4];

    always #2 clk = ~clk;

    dmac_ctrl_unit #(.NUM_CH(4)) i_dmac_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_idx(port_idx), .wr_data(wr_data), .hold_req(hold_req),
        .release_req(release_req), .term_cnt(term_cnt), .rd_data(rd_data),
        .ctrl_cmd(ctrl_cmd), .chan_mode(chan_mode), .run_en(run_en),
        .ff_clear(ff_clear), .port_err(port_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] idx);
        if (idx == 4'd8)  return stat_m;
        if (idx == 4'd15) return {4'h0, mask_m};
        return 8'h00;
    endfunction

    // One cycle of stimulus, reference update and output comparison
    task automatic step(input logic w, input logic r, input logic [3:0] idx,
                        input logic [7:0] d, input logic [3:0] h,
                        input logic [3:0] rl, input logic [3:0] t);
        logic ff_e, err_e;
        @(negedge clk);
        wr_en = w; rd_en = r; port_idx = idx; wr_data = d;
        hold_req = h; release_req = rl; term_cnt = t;
        #1;
        last_rd = rd_data;
        if (r) chk("R9 read data", rd_data, exp_read(idx));
        if (w) begin
            case (idx)
                4'd8:  if ((d & 8'hFB) == 8'h00) cmd_m = d;
                4'd9:  begin stat_m[4 + d[1:0]] = d[2]; stat_m[d[1:0]] = 1'b0; end
                4'd10: mask_m[d[1:0]] = d[2];
                4'd11: mode_m[d[1:0]] = d;
                4'd13: begin mask_m = 4'hF; stat_m = 8'h00; cmd_m = 8'h00; end
                4'd14: mask_m = 4'h0;
                4'd15: mask_m = d[3:0];
                default: ;
            endcase
        end
        if (r && idx == 4'd8) stat_m[3:0] = 4'h0;
        stat_m[3:0] = stat_m[3:0] | t;
        stat_m[7:4] = (stat_m[7:4] | h) & ~rl;
        ff_e  = w && (idx == 4'd12 || idx == 4'd13);
        err_e = (w || r) && !idx[3];
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; hold_req = '0; release_req = '0; term_cnt = '0;
        chk("R10 run_en", run_en, ~mask_m & stat_m[7:4]);
        chk("R2 command", ctrl_cmd, cmd_m);
        chk("R5 modes", chan_mode, {mode_m[3], mode_m[2], mode_m[1], mode_m[0]});
        chk("R6 ff_clear", ff_clear, ff_e);
        chk("R12 port_err", port_err, err_e);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        step(1'b1, 1'b0, idx, d, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic rd(input logic [3:0] idx);
        step(1'b0, 1'b1, idx, 8'h00, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic ext(input logic [3:0] h, input logic [3:0] rl, input logic [3:0] t);
        step(1'b0, 1'b0, 4'h8, 8'h00, h, rl, t);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wr_en = 0; rd_en = 0; port_idx = 0; wr_data = 0;
        hold_req = 0; release_req = 0; term_cnt = 0;
        cmd_m = 0; stat_m = 0; mask_m = 4'hF;
        for (int i = 0; i < 4; i++) mode_m[i] = 8'h00;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 run_en", run_en, 4'h0);
        chk("R1 command", ctrl_cmd, 8'h00);
        chk("R1 modes", chan_mode, 32'h0);
        rd(4'd15); chk("R1 mask", last_rd, 8'h0F);
        rd(4'd8);  chk("R1 status", last_rd, 8'h00);

        // R2 command acceptance
        wr(4'd8, 8'h10); chk("R2 reject 10", ctrl_cmd, 8'h00);
        wr(4'd8, 8'h04); chk("R2 accept 04", ctrl_cmd, 8'h04);
        wr(4'd8, 8'h05); chk("R2 reject 05", ctrl_cmd, 8'h04);
        wr(4'd8, 8'h00); chk("R2 accept 00", ctrl_cmd, 8'h00);

        // R3 request register, R10 eligibility
        wr(4'd9, 8'h06);
        chk("R10 masked", run_en, 4'h0);
        rd(4'd8); chk("R3 request set", last_rd, 8'h40);
        wr(4'd10, 8'h02); chk("R4 unmask ch2", run_en, 4'b0100);

        // R11 done bits, R9 clear on read
        ext(4'h0, 4'h0, 4'b0011);
        rd(4'd8); chk("R11 term set", last_rd, 8'h43);
        rd(4'd8); chk("R9 low cleared", last_rd, 8'h40);
        ext(4'h0, 4'h0, 4'b0100);
        wr(4'd9, 8'h02);
        rd(4'd8); chk("R3 request clear", last_rd, 8'h00);

        // R5 mode write
        wr(4'd11, 8'hA5); chk("R5 ch1 mode", chan_mode[15:8], 8'hA5);

        // R6 flip-flop clear pulse length
        wr(4'd12, 8'h00); chk("R6 pulse", ff_clear, 1'b1);
        ext(4'h0, 4'h0, 4'h0); chk("R6 pulse end", ff_clear, 1'b0);

        // R8 whole mask and clear
        wr(4'd15, 8'h0A); rd(4'd15); chk("R8 write all", last_rd, 8'h0A);
        wr(4'd14, 8'hFF); rd(4'd15); chk("R8 clear all", last_rd, 8'h00);

        // R11 hold and release ordering
        ext(4'b1001, 4'h0, 4'h0); chk("R11 hold", run_en, 4'b1001);
        ext(4'b0001, 4'b0001, 4'h0); chk("R11 release wins", run_en, 4'b1000);

        // R12 unknown port leaves state
        wr(4'd4, 8'hFF); chk("R12 flag", port_err, 1'b1);
        rd(4'd15); chk("R12 mask kept", last_rd, 8'h00);
        chk("R12 run kept", run_en, 4'b1000);

        // R7 master reset
        wr(4'd8, 8'h04);
        wr(4'd13, 8'h00);
        chk("R7 command", ctrl_cmd, 8'h00);
        chk("R7 run_en", run_en, 4'h0);
        chk("R7 ff_clear", ff_clear, 1'b1);
        chk("R7 mode kept", chan_mode[15:8], 8'hA5);
        rd(4'd15); chk("R7 mask", last_rd, 8'h0F);
        rd(4'd8);  chk("R7 status", last_rd, 8'h00);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] idx, h, rl, t;
            logic [7:0] d;
            int kind;
            kind = $urandom % 10;
            idx  = 4'd8 + 4'($urandom % 8);
            d    = 8'($urandom);
            if (idx == 4'd8 && ($urandom % 2) == 0) d = (($urandom % 2) == 0) ? 8'h04 : 8'h00;
            h  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            rl = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
            t  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            if (kind == 0) idx = 4'($urandom % 8);
            if (kind == 1 && ($urandom % 8) != 0 && idx == 4'd13) idx = 4'd10;
            if (kind < 6)
                step(1'b1, 1'b0, idx, d, h, rl, t);
            else if (kind < 9)
                step(1'b0, 1'b1, (($urandom % 2) == 0) ? 4'd8 : idx, 8'h00, h, rl, t);
            else
                step(1'b0, 1'b0, idx, 8'h00, h, rl, t);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule